// File: doc/BRIEF.md
# Dual-Master Downstream Channel Selector

This block decides which of two upstream bus masters is connected to a single shared downstream two-wire bus. Each master can ask for the bus at any moment by pulsing its request bit. The block then drives the enables of two pass-switch channels so that no more than one master is ever connected. Because either side may take the bus without the other's cooperation, a failed or removed master can be replaced by its partner.

The block also watches the downstream clock and data lines. A START condition marks the bus busy, and the matching STOP condition marks it idle again. When a handover happens while the bus is busy, the block raises a flag for one cycle. Software on the new master can use that flag to run a bus recovery of its own. The check is skipped when a separate recovery sequencer is in use, and it can also be switched off.

A parameter chooses the state after reset: channel 0 connected, or no channel connected.

Top module: `dual_master_sel`

## Requirements
- R1: At most one bit of `ch_en` is high in any cycle.
- R2: A request accepted at a clock edge drives both enables low for exactly one cycle. At the following edge the requested channel's enable goes high. `sel_req` = 2'b01 requests channel 0 (`ch_en` = 2'b01), and 2'b10 requests channel 1 (`ch_en` = 2'b10).
- R3: While `rst_n` is low at a clock edge, the block returns to its default state. `ch_en` becomes 2'b01 when `RESET_CH0` = 1 and 2'b00 when it is 0. `busy_switch_flag` becomes 0 and the bus is taken as idle.
- R4: A request naming the channel that is already the target leaves `ch_en` unchanged and raises no flag.
- R5: `sel_req` values 2'b00 and 2'b11 are ignored: `ch_en` does not change and no flag is raised.
- R6: An accepted switch made while the downstream bus is busy raises `busy_switch_flag` for exactly the one break cycle, provided `sensor_off` and `recov_on` are both 0.
- R7: The bus is busy from a START (SDA falls while SCL is high) until a STOP (SDA rises while SCL is high). SDA changes while SCL is low do not end the busy state. A switch made while the bus is idle raises no flag.
- R8: When `sensor_off` = 1 or `recov_on` = 1 at the request edge, an accepted switch on a busy bus raises no flag.
- R9: A reset during downstream traffic clears the busy state. A later switch, made with no new START, raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_req | input | 2 | One-cycle request pulse; bit i asks for channel i |
| sensor_off | input | 1 | 1 disables the busy-switch sensor |
| recov_on | input | 1 | 1 when the external recovery sequencer is in use; sensor inactive |
| scl_in | input | 1 | Downstream clock line level |
| sda_in | input | 1 | Downstream data line level |
| ch_en | output | 2 | Pass-switch enables, one per channel |
| busy_switch_flag | output | 1 | One-cycle pulse: a switch was made while the bus was busy |

## Verification
The selector is driven in two bus states: idle, and busy after a START. In each state the bench sends requests for the other channel, for the same channel, and the illegal codes. This separates a real handover from a no-change request, and a flagged switch from an unflagged one.

Busy-bus switches are repeated with each of the two disabling inputs set, to show that the flag is gated. A data-bit toggle with SCL low confirms that only a proper STOP clears the busy state. A reset in the middle of traffic shows that the busy state is cleared as well as the channel.

// File: rtl/dms_pkg.sv
// Shared types and helpers for the dual-master selector.
// Assumes exactly two upstream channels, one enable bit each.
package dms_pkg;
    typedef logic [1:0] chan_vec_t;

    localparam chan_vec_t CH_NONE = 2'b00;
    localparam chan_vec_t CH_ZERO = 2'b01;
    localparam chan_vec_t CH_ONE  = 2'b10;

    // True when the request names exactly one channel.
    function automatic logic single_chan(input chan_vec_t v);
        return (v == CH_ZERO) || (v == CH_ONE);
    endfunction
endpackage

// File: rtl/line_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes STAGES >= 2. The reset value is the line's idle level.
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_idle_monitor.sv
// Tracks whether the downstream two-wire bus is busy.
// A START (SDA falling while SCL high) sets busy.
// A STOP (SDA rising while SCL high) clears it.
// Assumes both lines idle high. Adds SYNC_STAGES+1 cycles of latency.
module bus_idle_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy
);
    logic scl_s, sda_s, sda_prev;
    logic start_det, stop_det;

    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    // Hold the previous synchronised SDA level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    assign start_det = scl_s &&  sda_prev && !sda_s;
    assign stop_det  = scl_s && !sda_prev &&  sda_s;

    // Set busy on START and clear it on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_det) bus_busy <= 1'b1;
        else if (stop_det)  bus_busy <= 1'b0;
    end
endmodule

// File: rtl/chan_ctrl.sv
// Channel ownership control with break-before-make enables.
// An accepted request clears both enables for one cycle, then connects the
// new target. Assumes sel_req is a one-cycle pulse; 00 and 11 are ignored.
module chan_ctrl
    import dms_pkg::*;
#(
    parameter bit RESET_CH0 = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_vec_t sel_req,
    input  logic      bus_busy,
    input  logic      sensor_off,
    input  logic      recov_on,
    output chan_vec_t ch_en,
    output logic      busy_switch_flag
);
    localparam chan_vec_t DEFAULT_CH = RESET_CH0 ? CH_ZERO : CH_NONE;

    chan_vec_t target;
    logic      accept;
    logic      sense_on;

    assign accept   = single_chan(sel_req) && (sel_req != target);
    assign sense_on = !sensor_off && !recov_on;

    // Update the target and run the break cycle before connecting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= DEFAULT_CH;
            ch_en  <= DEFAULT_CH;
        end else if (accept) begin
            target <= sel_req;
            ch_en  <= CH_NONE;
        end else begin
            ch_en  <= target;
        end
    end

    // Pulse the flag when a handover lands on a busy bus.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_switch_flag <= 1'b0;
        else        busy_switch_flag <= accept && bus_busy && sense_on;
    end
endmodule

// File: rtl/dual_master_sel.sv
// Top of the dual-master downstream channel selector.
// It combines the bus-idle monitor and the channel controller.
// Assumes one clock domain; scl_in and sda_in may be asynchronous.
module dual_master_sel #(
    parameter bit RESET_CH0   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_req,
    input  logic       sensor_off,
    input  logic       recov_on,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic [1:0] ch_en,
    output logic       busy_switch_flag
);
    logic bus_busy;

    bus_idle_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .bus_busy(bus_busy));

    chan_ctrl #(.RESET_CH0(RESET_CH0)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .bus_busy(bus_busy),
        .sensor_off(sensor_off), .recov_on(recov_on),
        .ch_en(ch_en), .busy_switch_flag(busy_switch_flag));
endmodule

// File: rtl/dms_checker.sv
// Property checker for dual_master_sel, bound to every instance.
module dms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel_req,
    input logic       sensor_off,
    input logic       recov_on,
    input logic [1:0] ch_en,
    input logic       busy_switch_flag
);
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en)); // R1

    AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != 2'b00 && !$stable(ch_en)) |-> $past(ch_en) == 2'b00); // R2

    AST_SAME_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req == ch_en && ch_en != 2'b00) |=> ($stable(ch_en) && !busy_switch_flag)); // R4

    AST_IGNORED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req == 2'b11 && ch_en != 2'b00) |=> ($stable(ch_en) && !busy_switch_flag)); // R5

    AST_FLAG_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_switch_flag |-> ch_en == 2'b00); // R6

    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_switch_flag |-> (!$past(sensor_off) && !$past(recov_on))); // R8
endmodule

bind dual_master_sel dms_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sensor_off(sensor_off),
    .recov_on(recov_on), .ch_en(ch_en), .busy_switch_flag(busy_switch_flag));

// File: tb/dual_master_sel_bench.sv
module dual_master_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_req = 2'b00;
    logic       sensor_off = 1'b0;
    logic       recov_on = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [1:0] ch_en;
    logic       busy_switch_flag;

    int checks = 0;
    int fails  = 0;
    logic bus_is_busy = 1'b0;

    always #5 clk = ~clk;

    dual_master_sel u_dual_master_sel (
        .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sensor_off(sensor_off),
        .recov_on(recov_on), .scl_in(scl_in), .sda_in(sda_in),
        .ch_en(ch_en), .busy_switch_flag(busy_switch_flag));

    // Vector fields: {busy, s_off, r_on, req[1:0], brk, exp_flag, exp_en[1:0]}
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        9'b0_0_0_10_1_0_10,  // idle switch to ch1, no flag (R2, R7)
        9'b0_0_0_10_0_0_10,  // same channel (R4)
        9'b1_0_0_01_1_1_01,  // busy switch, flag (R6)
        9'b1_0_0_01_0_0_01,  // same channel while busy (R4)
        9'b1_1_0_10_1_0_10,  // sensor off (R8)
        9'b1_0_1_01_1_0_01,  // recovery in use (R8)
        9'b1_0_0_11_0_0_01,  // both bits, ignored (R5)
        9'b0_0_0_10_1_0_10,  // after STOP, idle (R7)
        9'b1_0_0_01_1_1_01   // busy again (R6)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_bus(input logic busy);
        if (busy && !bus_is_busy) begin
            scl_in = 1'b1; sda_in = 1'b1; settle();
            sda_in = 1'b0; settle();
        end else if (!busy && bus_is_busy) begin
            scl_in = 1'b1; sda_in = 1'b0; settle();
            sda_in = 1'b1; settle();
        end
        bus_is_busy = busy;
    endtask

    task automatic do_req(input logic [1:0] r, input logic brk, input logic fl,
                          input logic [1:0] en, input string tag);
        @(negedge clk);
        sel_req = r;
        @(posedge clk); #1;
        check({tag, " break en"}, 32'(ch_en), brk ? 32'd0 : 32'(en));
        check({tag, " flag"}, 32'(busy_switch_flag), 32'(fl));
        @(negedge clk);
        sel_req = 2'b00;
        @(posedge clk); #1;
        check({tag, " final en"}, 32'(ch_en), 32'(en));
        check({tag, " flag clear"}, 32'(busy_switch_flag), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset en", 32'(ch_en), 32'd1);
        check("R3 reset flag", 32'(busy_switch_flag), 32'd0);
        rst_n = 1'b1;
        settle();
        check("R3 after release en", 32'(ch_en), 32'd1);

        for (int i = 0; i < NV; i++) begin
            set_bus(VEC[i][8]);
            @(negedge clk);
            sensor_off = VEC[i][7];
            recov_on   = VEC[i][6];
            do_req(VEC[i][5:4], VEC[i][3], VEC[i][2], VEC[i][1:0], $sformatf("R2/R6 vec%0d", i));
        end
        sensor_off = 1'b0; recov_on = 1'b0;

        // R5: an all-zero request changes nothing
        do_req(2'b00, 1'b0, 1'b0, 2'b01, "R5 zero req");

        // R7: a data toggle with SCL low keeps the bus busy
        scl_in = 1'b0; settle();
        sda_in = 1'b1; settle();
        scl_in = 1'b1; settle();
        scl_in = 1'b0; settle();
        sda_in = 1'b0; settle();
        scl_in = 1'b1; settle();
        do_req(2'b10, 1'b1, 1'b1, 2'b10, "R7 still busy");

        // R9: reset during traffic clears busy and restores the default
        @(negedge clk);
        rst_n = 1'b0;
        scl_in = 1'b1; sda_in = 1'b1;
        bus_is_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset en", 32'(ch_en), 32'd1);
        check("R9 reset flag", 32'(busy_switch_flag), 32'd0);
        rst_n = 1'b1;
        settle();
        do_req(2'b10, 1'b1, 1'b0, 2'b10, "R9 idle after reset");

        // R2: back-to-back takeover by the other master
        do_req(2'b01, 1'b1, 1'b0, 2'b01, "R2 takeover");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule